// File: doc/BRIEF.md
# Audio Sample Record and Playback Controller

This controller captures a fixed run of audio samples into a single-port RAM and replays them later. A record request starts a pass that loads one sample from the analog-to-digital converter every cycle. The controller turns on the buffer that gates the sample onto the RAM write bus, and writes the sample at the next address. A play request starts a pass that reads the same addresses in the same order. Each word's converter load strobe comes one cycle after its read, when the synchronous RAM has put the word on its read bus.

Both passes share one address register. It starts at zero and moves up by one after every access. The access at the top address ends the pass. A one-cycle done pulse follows, and then the controller goes back to idle, where it accepts the next request. Samples are narrower than RAM words and are zero-extended into the low bits of each word.

Top module: `audio_rec_play_ctrl`

## Requirements
- R1: After reset and while idle, ram_en, ram_we, adc_ld, adc_buf_en, dac_ld and done are all low, and ram_addr is 0 after reset.
- R2: A record pass makes exactly 4096 consecutive access cycles with ram_en=1, ram_we=1, adc_ld=1 and adc_buf_en=1, with ram_addr going from 0 up to 4095 in steps of one.
- R3: ram_wdata bits 15:12 are always 0. While adc_buf_en=1, bits 11:0 equal adc_sample, and while adc_buf_en=0 the whole bus is 0.
- R4: A play pass makes exactly 4096 consecutive read cycles with ram_en=1, ram_we=0, adc_ld=0 and adc_buf_en=0, with ram_addr going from 0 up to 4095.
- R5: dac_ld is high exactly in the cycle after each play read and at no other time. dac_data carries bits 11:0 of ram_rdata, so in that cycle it equals the sample recorded at the address just read.
- R6: done is high for exactly one cycle, the cycle right after the last access of a pass, with ram_en low. The controller is idle in the cycle after that.
- R7: If rec_req and play_req are both high in an idle cycle, a record pass starts.
- R8: Requests made while a pass or its done cycle is in progress are ignored. The pass keeps its mode and its length of 4096.
- R9: A request sampled at a clock edge while idle makes the first access, at address 0, in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_req | input | 1 | Start a record pass |
| play_req | input | 1 | Start a play pass |
| adc_sample | input | 12 | Sample from the analog-to-digital converter |
| ram_rdata | input | 16 | RAM read data, valid one cycle after a read |
| ram_addr | output | 12 | RAM word address |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write (1) or read (0) |
| ram_wdata | output | 16 | Zero-extended sample gated onto the RAM write bus |
| adc_ld | output | 1 | Analog-to-digital converter load strobe |
| adc_buf_en | output | 1 | Drive enable of the sample buffer onto the RAM bus |
| dac_ld | output | 1 | Digital-to-analog converter load strobe |
| dac_data | output | 12 | Sample presented to the digital-to-analog converter |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
Two situations are hard to reach from the ports. One is a conflicting request that arrives while a pass is running, long after the pass started. The other is the link from a read at the top address to its converter load, which happens only after 4095 earlier accesses. The stimulus keeps whole passes running. It raises the opposite request part way through each pass, and it holds play_req high across two passes so that they run back to back. A bench RAM records what was written, and every play load is compared with the sample that was captured at the address read one cycle earlier.

// File: rtl/audio_rec_play_ctrl.sv
module audio_rec_play_ctrl #(
  parameter int ADDR_W   = 12,
  parameter int WORD_W   = 16,
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rec_req,
  input  logic                play_req,
  input  logic [SAMPLE_W-1:0] adc_sample,
  input  logic [WORD_W-1:0]   ram_rdata,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic                ram_en,
  output logic                ram_we,
  output logic [WORD_W-1:0]   ram_wdata,
  output logic                adc_ld,
  output logic                adc_buf_en,
  output logic                dac_ld,
  output logic [SAMPLE_W-1:0] dac_data,
  output logic                done
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam int PAD_W = WORD_W - SAMPLE_W;

  typedef enum logic [2:0] {IDLE, REC, PLAY, REC_END, PLAY_END} state_t;

  state_t            state;
  logic [ADDR_W-1:0] a;
  logic              read_q;
  logic              at_last;
  logic              unused_hi;

  assign at_last = (a == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= IDLE;
      a      <= '0;
      read_q <= 1'b0;
    end else begin
      read_q <= (state == PLAY);
      case (state)
        IDLE: begin
          if (rec_req) begin
            state <= REC;
            a     <= '0;
          end else if (play_req) begin
            state <= PLAY;
            a     <= '0;
          end
        end
        REC: begin
          if (at_last) state <= REC_END;
          else         a     <= a + 1'b1;
        end
        PLAY: begin
          if (at_last) state <= PLAY_END;
          else         a     <= a + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign ram_addr   = a;
  assign ram_en     = (state == REC) || (state == PLAY);
  assign ram_we     = (state == REC);
  assign adc_ld     = (state == REC);
  assign adc_buf_en = (state == REC);
  assign ram_wdata  = adc_buf_en ? {{PAD_W{1'b0}}, adc_sample} : '0;
  assign dac_ld     = read_q;
  assign dac_data   = ram_rdata[SAMPLE_W-1:0];
  assign done       = (state == REC_END) || (state == PLAY_END);
  assign unused_hi  = ^ram_rdata[WORD_W-1:SAMPLE_W];
endmodule

// File: rtl/audio_rec_play_ctrl_chk.sv
module audio_rec_play_ctrl_chk #(
  parameter int ADDR_W   = 12,
  parameter int WORD_W   = 16,
  parameter int SAMPLE_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SAMPLE_W-1:0] adc_sample,
  input logic [ADDR_W-1:0]   ram_addr,
  input logic                ram_en,
  input logic                ram_we,
  input logic [WORD_W-1:0]   ram_wdata,
  input logic                adc_ld,
  input logic                adc_buf_en,
  input logic                dac_ld,
  input logic                done
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_en |-> (!ram_we && !adc_ld && !adc_buf_en));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && $past(ram_en)) |-> (ram_addr == $past(ram_addr) + 1'b1));

  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wdata[WORD_W-1:SAMPLE_W] == '0);

  assert_sample_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_buf_en |-> (ram_wdata[SAMPLE_W-1:0] == adc_sample));

  assert_read_no_adc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !ram_we) |-> (!adc_ld && !adc_buf_en));

  assert_dac_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !ram_we) |=> dac_ld);

  assert_dac_only_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_en || ram_we) |=> !dac_ld);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ram_en ##1 (!done && !ram_en)));
endmodule

bind audio_rec_play_ctrl audio_rec_play_ctrl_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_sample(adc_sample), .ram_addr(ram_addr),
  .ram_en(ram_en), .ram_we(ram_we), .ram_wdata(ram_wdata), .adc_ld(adc_ld),
  .adc_buf_en(adc_buf_en), .dac_ld(dac_ld), .done(done)
);

// File: tb/audio_rec_play_ctrl_test.sv
module audio_rec_play_ctrl_test;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_req = 1'b0;
  logic        play_req = 1'b0;
  logic [11:0] adc_sample = '0;
  logic [15:0] ram_rdata = '0;
  logic [11:0] ram_addr;
  logic        ram_en, ram_we, adc_ld, adc_buf_en, dac_ld, done;
  logic [15:0] ram_wdata;
  logic [11:0] dac_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int seed = 5;

  always #10 clk = ~clk;

  audio_rec_play_ctrl uut (
    .clk(clk), .rst_n(rst_n), .rec_req(rec_req), .play_req(play_req),
    .adc_sample(adc_sample), .ram_rdata(ram_rdata), .ram_addr(ram_addr),
    .ram_en(ram_en), .ram_we(ram_we), .ram_wdata(ram_wdata), .adc_ld(adc_ld),
    .adc_buf_en(adc_buf_en), .dac_ld(dac_ld), .dac_data(dac_data), .done(done)
  );

  logic [15:0] mem [DEPTH];
  always @(posedge clk) begin
    if (ram_en && ram_we)  mem[ram_addr] <= ram_wdata;
    if (ram_en && !ram_we) ram_rdata <= mem[ram_addr];
  end

  int phase = 0;
  int idx = 0;
  int last_rd = 0;
  bit pdl = 0;
  int pass_len = 0;
  logic [11:0] store [DEPTH];

  always @(posedge clk) begin
    bit nxt_pdl;
    if (!rst_n) begin
      phase = 0; idx = 0; pdl = 0;
    end else begin
      nxt_pdl = (phase == 2);
      case (phase)
        0: if (rec_req) begin phase = 1; idx = 0; end
           else if (play_req) begin phase = 2; idx = 0; end
        1: begin
          store[idx] = adc_sample;
          if (idx == DEPTH-1) phase = 3; else idx++;
        end
        2: begin
          last_rd = idx;
          if (idx == DEPTH-1) phase = 4; else idx++;
        end
        default: phase = 0;
      endcase
      pdl = nxt_pdl;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit e_en, e_we;
    cyc++;
    e_en = (phase == 1) || (phase == 2);
    e_we = (phase == 1);
    chk(ram_en == e_en, "R2/R4 ram_en", int'(ram_en), int'(e_en));
    chk(ram_we == e_we, "R2/R4 ram_we", int'(ram_we), int'(e_we));
    chk(adc_ld == e_we && adc_buf_en == e_we, "R2/R4 adc_ld/adc_buf_en",
        int'({adc_ld, adc_buf_en}), int'({e_we, e_we}));
    if (e_en) chk(ram_addr == 12'(idx), "R2/R4 ram_addr", int'(ram_addr), idx);
    chk(ram_wdata == (e_we ? {4'h0, adc_sample} : 16'h0), "R3 ram_wdata",
        int'(ram_wdata), e_we ? int'(adc_sample) : 0);
    chk(dac_ld == pdl, "R5 dac_ld", int'(dac_ld), int'(pdl));
    if (pdl) chk(dac_data == store[last_rd], "R5 dac_data",
                 int'(dac_data), int'(store[last_rd]));
    chk(done == (phase == 3 || phase == 4), "R6 done", int'(done), int'(phase == 3 || phase == 4));
    if (!rst_n || phase == 0)
      chk(!ram_en && !adc_ld && !dac_ld && !done, "R1 idle quiet",
          int'({ram_en, adc_ld, dac_ld, done}), 0);
    if (ram_en) pass_len++;
    if (done) begin
      chk(pass_len == DEPTH, "R8 pass length", pass_len, DEPTH);
      pass_len = 0;
    end
  end

  task automatic step();
    @(negedge clk);
    #2;
    adc_sample = 12'((cyc * 37 + seed * 101) & 12'hFFF);
  endtask

  task automatic run_until_done();
    for (int i = 0; i < DEPTH + 20; i++) begin
      step();
      if (done) break;
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'h0;
    repeat (3) step();
    chk(ram_addr == 12'h0 && !ram_en && !done, "R1 reset state", int'(ram_addr), 0);
    rst_n = 1'b1;
    repeat (4) step();

    rec_req = 1'b1; play_req = 1'b1;
    step();
    chk(ram_we == 1'b1 && ram_en == 1'b1, "R7 record wins", int'({ram_en, ram_we}), 3);
    chk(ram_addr == 12'h0, "R9 first address", int'(ram_addr), 0);
    rec_req = 1'b0; play_req = 1'b0;
    repeat (300) step();
    play_req = 1'b1;
    repeat (5) step();
    chk(ram_we == 1'b1, "R8 play ignored during record", int'(ram_we), 1);
    play_req = 1'b0;
    run_until_done();
    repeat (3) step();

    play_req = 1'b1;
    step();
    play_req = 1'b0;
    chk(ram_en && !ram_we && ram_addr == 12'h0, "R9 play start",
        int'({ram_en, ram_we}), 2);
    repeat (1000) step();
    rec_req = 1'b1;
    repeat (3) step();
    chk(!ram_we && !adc_buf_en, "R8 record ignored during play", int'(ram_we), 0);
    rec_req = 1'b0;
    run_until_done();
    rec_req = 1'b1;
    step();
    rec_req = 1'b0;
    chk(!ram_en, "R8 request in done cycle ignored", int'(ram_en), 0);
    repeat (3) step();

    seed = 77;
    rec_req = 1'b1;
    step();
    rec_req = 1'b0;
    run_until_done();
    repeat (2) step();
    play_req = 1'b1;
    run_until_done();
    run_until_done();
    play_req = 1'b0;
    repeat (5) step();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule